// File: doc/BRIEF.md
# Bypassable Asynchronous-Force Macrocell Bank

This block is a bank of independent logic-array output cells. Each cell holds one flip-flop that is clocked by its own clock term, which is built by logic rather than taken from a shared clock pin. Two asynchronous control terms act on the flip-flop: a set term forces it to one and a clear term forces it to zero, without waiting for a clock. When both control terms are high at once there is no winner. The flip-flop is stepped around instead, and the cell value tracks the data term combinationally, which lets the same cell serve as a plain combinational output.

The value leaving the register-or-bypass selector passes through a per-cell polarity inverter and then to a tri-state pin. The pin is driven only when the bank-wide active-low enable pin is low and the cell's own enable term is high. The only feedback into the array comes back from the pin, so a cell whose output is off returns whatever the outside world drives on that pin.

Top module: `bypass_macrocell_bank`

## Requirements
- R1: With the set term high and the clear term low, the cell's stored value becomes 1 at once, with no clock edge needed.
- R2: With the clear term high and the set term low, the cell's stored value becomes 0 at once, with no clock edge needed.
- R3: With set and clear both high, the pin value equals the data term (after polarity) and follows data changes with no clock edge.
- R4: With set and clear both low, the stored value takes the data term on each rising edge of the cell's clock term and holds between edges.
- R5: Rising clock edges while exactly one of set or clear is high leave the forced value in place; after release the forced value holds until the next rising clock edge.
- R6: A rising clock edge while set and clear are both high loads the data term into the stored value, which appears on the pin once both terms fall.
- R7: With the global enable pin low (0), a cell drives its pin only while its local enable term is 1; cells whose local term is 0 leave the pin to the outside.
- R8: With the global enable pin high (1), every pin is released whatever the local enable terms.
- R9: The feedback output of each cell always equals the level on its pin, so a released pin returns the externally driven value.
- R10: A polarity bit of 1 inverts the value driven on the pin, applied after the register/bypass choice; 0 passes it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| d_term | input | CELLS | Sum-term data per cell |
| clk_term | input | CELLS | Logic-generated clock per cell, rising edge |
| set_term | input | CELLS | Asynchronous force-to-one per cell |
| clr_term | input | CELLS | Asynchronous force-to-zero per cell |
| loe_term | input | CELLS | Local output-enable term per cell, active high |
| goe_n | input | 1 | Bank-wide output enable, active low |
| inv_sel | input | CELLS | Per-cell output polarity, 1 inverts |
| pad | inout | CELLS | Tri-state output pins |
| fb | output | CELLS | Feedback taken from the pins |

## Verification
The bench goes after the transitions between force states: going from both terms high to one high must refresh the forced value, and a design that only reacts to the raw set or clear edge would keep a stale zero there. It clocks cells while a force is held and while in bypass, so a design that let the clock beat the force would lose the forced value, and one that froze the register during bypass would show old data afterwards. It drives released pins from outside with values opposite to the cell's own, so feedback taken from the register instead of the pin, or an enable that ignores the global pin, shows up at once as a mismatch.

// File: rtl/mc_pkg.sv
package mc_pkg;

  // Value presented to the pin stage: register or bypass, then polarity.
  function automatic logic mc_pick(input logic byp, input logic d,
                                   input logic q, input logic inv);
    return (byp ? d : q) ^ inv;
  endfunction

  // Pin drive condition: global active-low pin gated with the local term.
  function automatic logic mc_enable(input logic goe_n, input logic loe);
    return ~goe_n & loe;
  endfunction

endpackage

// File: rtl/mc_async_reg.sv
module mc_async_reg (
  input  logic clk,
  input  logic d,
  input  logic set,
  input  logic clr,
  output logic q
);
  // Single-sided force events: a move from "both high" to "one high"
  // produces a fresh edge so the surviving force takes effect.
  logic set_only;
  logic clr_only;

  assign set_only = set & ~clr;
  assign clr_only = clr & ~set;

  always_ff @(posedge clk or posedge set_only or posedge clr_only) begin
    if (clr_only)      q <= 1'b0;
    else if (set_only) q <= 1'b1;
    else               q <= d;
  end
endmodule

// File: rtl/mc_out_path.sv
module mc_out_path
  import mc_pkg::*;
(
  input  logic byp,
  input  logic d,
  input  logic q,
  input  logic inv,
  input  logic loe,
  input  logic goe_n,
  output logic val,
  output logic en
);
  assign val = mc_pick(byp, d, q, inv);
  assign en  = mc_enable(goe_n, loe);
endmodule

// File: rtl/mc_pad.sv
module mc_pad (
  input  logic en,
  input  logic val,
  inout  wire  pad,
  output logic fb
);
  assign pad = en ? val : 1'bz;
  assign fb  = pad;
endmodule

// File: rtl/bypass_macrocell_bank.sv
module bypass_macrocell_bank #(
  parameter int CELLS = 4
) (
  input  logic [CELLS-1:0] d_term,
  input  logic [CELLS-1:0] clk_term,
  input  logic [CELLS-1:0] set_term,
  input  logic [CELLS-1:0] clr_term,
  input  logic [CELLS-1:0] loe_term,
  input  logic             goe_n,
  input  logic [CELLS-1:0] inv_sel,
  inout  wire  [CELLS-1:0] pad,
  output logic [CELLS-1:0] fb
);
  localparam int LAST = CELLS - 1;

  // Named internal events, exposed for the assertions below.
  logic [LAST:0] bypass_w;
  logic [LAST:0] q_w;
  logic [LAST:0] pin_val_w;
  logic [LAST:0] drv_en_w;

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    assign bypass_w[i] = set_term[i] & clr_term[i];

    mc_async_reg u_reg (
      .clk (clk_term[i]),
      .d   (d_term[i]),
      .set (set_term[i]),
      .clr (clr_term[i]),
      .q   (q_w[i])
    );

    mc_out_path u_out (
      .byp   (bypass_w[i]),
      .d     (d_term[i]),
      .q     (q_w[i]),
      .inv   (inv_sel[i]),
      .loe   (loe_term[i]),
      .goe_n (goe_n),
      .val   (pin_val_w[i]),
      .en    (drv_en_w[i])
    );

    mc_pad u_pad (
      .en  (drv_en_w[i]),
      .val (pin_val_w[i]),
      .pad (pad[i]),
      .fb  (fb[i])
    );

    AST_SET_FORCES_ONE: assert property (@(posedge clk_term[i])
      (set_term[i] && !clr_term[i]) |-> q_w[i]); // R1

    AST_CLR_FORCES_ZERO: assert property (@(posedge clk_term[i])
      (clr_term[i] && !set_term[i]) |-> !q_w[i]); // R2

    AST_BYPASS_TRACKS_DATA: assert property (@(posedge clk_term[i])
      (set_term[i] && clr_term[i]) |-> (pad[i] == (d_term[i] ^ inv_sel[i])) || !drv_en_w[i]); // R3

    AST_LOCAL_ENABLE_DRIVES: assert property (@(posedge clk_term[i])
      (!goe_n && loe_term[i]) |-> drv_en_w[i]); // R7

    AST_GLOBAL_DISABLE: assert property (@(posedge clk_term[i])
      goe_n |-> !drv_en_w[i]); // R8

    AST_FB_FROM_PIN: assert property (@(posedge clk_term[i])
      drv_en_w[i] |-> (fb[i] == pin_val_w[i])); // R9
  end
endmodule

// File: tb/sim_bypass_macrocell_bank.sv
`timescale 1ns/1ps
module sim_bypass_macrocell_bank;
  localparam int N = 4;

  logic         tb_clk = 1'b0;
  logic [N-1:0] d_term   = '0;
  logic [N-1:0] clk_term = '0;
  logic [N-1:0] set_term = '0;
  logic [N-1:0] clr_term = '1;
  logic [N-1:0] loe_term = '1;
  logic         goe_n    = 1'b0;
  logic [N-1:0] inv_sel  = '0;
  logic [N-1:0] ext_val  = '0;
  logic [N-1:0] ext_on;
  wire  [N-1:0] pad;
  logic [N-1:0] fb;

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  bit    active = 1'b0;
  bit    done   = 1'b0;
  string tag    = "R2";
  bit    model_q [N];

  always #2 tb_clk = ~tb_clk;

  // Outside world drives a pin only while the cell lets go of it.
  always_comb
    for (int i = 0; i < N; i++) ext_on[i] = goe_n | ~loe_term[i];

  for (genvar i = 0; i < N; i++) begin : g_ext
    assign pad[i] = ext_on[i] ? ext_val[i] : 1'bz;
  end

  bypass_macrocell_bank #(.CELLS(N)) u0 (
    .d_term(d_term), .clk_term(clk_term), .set_term(set_term),
    .clr_term(clr_term), .loe_term(loe_term), .goe_n(goe_n),
    .inv_sel(inv_sel), .pad(pad), .fb(fb)
  );

  initial for (int i = 0; i < N; i++) model_q[i] = 1'b0;

  // Reference behaviour, compared on every falling edge.
  always @(negedge tb_clk) begin
    cycles++;
    if (active) begin
      for (int i = 0; i < N; i++) begin
        bit shown, expect_pin;
        if (set_term[i] === 1'b1 && clr_term[i] === 1'b1) shown = d_term[i];
        else shown = model_q[i];
        if (inv_sel[i]) shown = !shown;
        if (!goe_n && loe_term[i]) expect_pin = shown;
        else expect_pin = ext_val[i];
        checks++;
        if (pad[i] !== expect_pin) begin
          errors++;
          $display("FAIL %s cell %0d pad: got %b expected %b", tag, i, pad[i], expect_pin);
        end
        checks++;
        if (fb[i] !== expect_pin) begin
          errors++;
          $display("FAIL %s cell %0d fb: got %b expected %b", tag, i, fb[i], expect_pin);
        end
      end
    end
  end

  task automatic drive(input logic [N-1:0] nd, input logic [N-1:0] ns,
                       input logic [N-1:0] nc);
    @(posedge tb_clk); #1;
    d_term = nd; set_term = ns; clr_term = nc;
    for (int i = 0; i < N; i++) begin
      if (ns[i] && !nc[i]) model_q[i] = 1'b1;
      if (nc[i] && !ns[i]) model_q[i] = 1'b0;
    end
  endtask

  task automatic pulse(input logic [N-1:0] mask);
    @(posedge tb_clk); #1;
    clk_term = mask;
    for (int i = 0; i < N; i++)
      if (mask[i] && (set_term[i] == clr_term[i])) model_q[i] = d_term[i];
    @(posedge tb_clk); #1;
    clk_term = '0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(posedge tb_clk);
  endtask

  initial begin
    idle(2);
    active = 1'b1;
    tag = "R2"; drive(4'b1111, 4'b0000, 4'b1111); idle(2);
    tag = "R1"; drive(4'b0000, 4'b0101, 4'b0000); idle(2);
    tag = "R2"; drive(4'b1111, 4'b0000, 4'b0101); idle(2);
    tag = "R4"; drive(4'b1010, 4'b0000, 4'b0000); idle(1);
    pulse(4'b1111); idle(1);
    drive(4'b0110, 4'b0000, 4'b0000); idle(2);   // no edge: R4 hold
    pulse(4'b0011); idle(1);
    drive(4'b1001, 4'b0000, 4'b0000);
    pulse(4'b1100); idle(1);
    tag = "R5"; drive(4'b0000, 4'b1100, 4'b0011);
    pulse(4'b1111); idle(1);
    drive(4'b0011, 4'b0000, 4'b0000); idle(2);   // released, held
    pulse(4'b0101); idle(2);
    tag = "R3"; drive(4'b0000, 4'b1111, 4'b1111); idle(1);
    drive(4'b1111, 4'b1111, 4'b1111); idle(1);
    drive(4'b0110, 4'b1111, 4'b1111); idle(1);
    drive(4'b1001, 4'b1111, 4'b1111); idle(1);
    tag = "R1"; drive(4'b0000, 4'b1111, 4'b0000); idle(1); // both -> set only
    tag = "R2"; drive(4'b1111, 4'b1111, 4'b1111); idle(1);
    drive(4'b1111, 4'b0000, 4'b1111); idle(1);             // both -> clear only
    tag = "R6"; drive(4'b1011, 4'b1111, 4'b1111);
    pulse(4'b1111);
    drive(4'b0100, 4'b1111, 4'b1111); idle(1);
    drive(4'b0100, 4'b0000, 4'b0000); idle(2);
    tag = "R10";
    @(posedge tb_clk); #1; inv_sel = 4'b0110; idle(2);
    drive(4'b0101, 4'b1111, 4'b1111); idle(1);
    @(posedge tb_clk); #1; inv_sel = 4'b1001; idle(1);
    drive(4'b0101, 4'b0000, 4'b0000); idle(1);
    tag = "R7";
    @(posedge tb_clk); #1; loe_term = 4'b0101; ext_val = 4'b1111; idle(2);
    @(posedge tb_clk); #1; loe_term = 4'b1010; ext_val = 4'b0000; idle(2);
    tag = "R8";
    @(posedge tb_clk); #1; goe_n = 1'b1; loe_term = 4'b1111; ext_val = 4'b0110; idle(2);
    tag = "R9";
    @(posedge tb_clk); #1; ext_val = 4'b1001; idle(2);
    @(posedge tb_clk); #1; ext_val = 4'b1111; idle(1);
    pulse(4'b1111); idle(1);                               // register moves, pins stay outside
    @(posedge tb_clk); #1; goe_n = 1'b0; idle(2);
    active = 1'b0;
    done = 1'b1;
  end

  initial begin
    while (!done && cycles < 20000) @(posedge tb_clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule